// File: doc/BRIEF.md
# NAND Erase-Block Program-Rule Tracker

This block guards one erase block of a NAND array by holding the program and read state of every page in that block. A controller sends it one command at a time. Each command names an operation and a page, plus a sub-page index for partial programs. The tracker checks the command against the rules of the medium. A legal command updates the tracker's state. An illegal command is refused and leaves the state untouched. One cycle later the tracker returns a result code together with the page's status after the update.

Each page is split logically into four quarters. A quarter may be programmed once between erasures. A whole-page program needs a completely blank page. Programs must move upward through the block: no program may target a page below the highest page already programmed.

Each programmed page also keeps a read counter. When that counter reaches a configurable limit, the tracker raises a refresh request for the page so that the data can be rewritten clean. A block-level flag shows when every programmed page has been marked obsolete, which means the block can be erased without moving any data.

Top module: `nand_page_tracker`

## Requirements
- R1: `cmd_ready` is high whenever reset is released. Every accepted command (`cmd_valid` and `cmd_ready` high at a rising edge) produces exactly one response on the next cycle: `rsp_valid` high with `rsp_code` and the addressed page's updated status. `rsp_valid` is low in cycles after edges with no accepted command.
- R2: A full program (op 0) to a page with no quarter written, at or above the highest programmed page, returns code 0 and leaves `rsp_parts` = 4'b1111, `rsp_used` = 1 and `rsp_full` = 1.
- R3: A full program to a page with any quarter written, or a partial program (op 1) to a quarter that is already written, returns code 1 and changes nothing.
- R4: A full or partial program to a page index below the highest page programmed since the last erase returns code 2 and changes nothing. Code 2 takes priority over code 1.
- R5: A partial program sets only bit `cmd_part` of the page's `rsp_parts`. The page reads as used once any quarter is written, and as full only when all four are written.
- R6: Erase (op 4) returns code 0. It frees every page and quarter, clears every obsolete flag, read counter and refresh flag, and resets the ordering rule so that any page may be programmed next.
- R7: Invalidate (op 3) on a used page sets its obsolete flag and returns code 0. On a free page it returns code 3 and changes nothing.
- R8: Read (op 2) on a used page returns code 0 and increments that page's read count, saturating at READ_LIMIT. When the count equals READ_LIMIT, `rsp_refresh` is high for that page and `refresh_req` is high. A read of a free page returns code 3 and does not count.
- R9: `all_obsolete` is high exactly when every used page is obsolete. This includes the state in which no page is used.
- R10: Op codes 5 to 7 return code 3 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | 0 program, 1 partial, 2 read, 3 invalidate, 4 erase |
| cmd_page | input | $clog2(PAGES) | Page index |
| cmd_part | input | 2 | Quarter index for partial program |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 accepted, 1 rewrite, 2 order, 3 illegal state or op |
| rsp_parts | output | 4 | Written-quarter mask of the page |
| rsp_used | output | 1 | Page has any quarter written |
| rsp_full | output | 1 | Page has all quarters written |
| rsp_obsolete | output | 1 | Page is marked obsolete |
| rsp_refresh | output | 1 | Page read count reached the limit |
| all_obsolete | output | 1 | Every used page is obsolete |
| refresh_req | output | 1 | Some page needs a refresh |

## Verification
The bench targets the rule boundaries, and each has a typical failure:
- A partial program that fills the last free quarter. A design that gets this wrong reports the page full too early or refuses the final quarter.
- A program to the page directly below the highest one. A design with a faulty ordering check accepts it, or refuses a program to the highest page itself.
- A rewrite that is also out of order. This must report the order code; swapping the priority gives the rewrite code instead.
- The read that lands exactly on the limit. An off-by-one counter raises the refresh one read early or one read late.
- The sweep also mixes erases into a long command stream. A partial clear would leave stale quarters, counters or the highest-page mark, and later programs would then be refused.

// File: rtl/nand_page_tracker.sv
module nand_page_tracker #(
  parameter int PAGES = 64,
  parameter int READ_LIMIT = 1000,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(READ_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [PW-1:0] cmd_page,
  input  logic [1:0]    cmd_part,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [3:0]    rsp_parts,
  output logic          rsp_used,
  output logic          rsp_full,
  output logic          rsp_obsolete,
  output logic          rsp_refresh,
  output logic          all_obsolete,
  output logic          refresh_req
);

  logic [3:0]    parts_q [PAGES];
  logic          obs_q   [PAGES];
  logic [CW-1:0] rd_q    [PAGES];
  logic [PW-1:0] hi_q;
  logic          any_q;

  logic          take;
  logic [3:0]    cur_parts, bit_sel, n_parts;
  logic          n_obs, order_bad, prog_ok;
  logic [CW-1:0] n_rd;
  logic [1:0]    code;

  assign cmd_ready = rst_n;
  assign take      = cmd_valid && cmd_ready;
  assign cur_parts = parts_q[cmd_page];
  assign bit_sel   = 4'b0001 << cmd_part;
  assign order_bad = any_q && (cmd_page < hi_q);
  assign prog_ok   = (cmd_op == 3'd0 || cmd_op == 3'd1) && code == 2'd0;

  always_comb begin
    code    = 2'd0;
    n_parts = cur_parts;
    n_obs   = obs_q[cmd_page];
    n_rd    = rd_q[cmd_page];
    case (cmd_op)
      3'd0: if (order_bad) code = 2'd2;
            else if (cur_parts != 4'd0) code = 2'd1;
            else n_parts = 4'hF;
      3'd1: if (order_bad) code = 2'd2;
            else if ((cur_parts & bit_sel) != 4'd0) code = 2'd1;
            else n_parts = cur_parts | bit_sel;
      3'd2: if (cur_parts == 4'd0) code = 2'd3;
            else if (rd_q[cmd_page] < CW'(READ_LIMIT)) n_rd = rd_q[cmd_page] + 1'b1;
      3'd3: if (cur_parts == 4'd0) code = 2'd3;
            else n_obs = 1'b1;
      3'd4: begin
        n_parts = 4'd0;
        n_obs   = 1'b0;
        n_rd    = '0;
      end
      default: code = 2'd3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) begin
        parts_q[i] <= 4'd0;
        obs_q[i]   <= 1'b0;
        rd_q[i]    <= '0;
      end
      hi_q  <= '0;
      any_q <= 1'b0;
    end else if (take) begin
      if (cmd_op == 3'd4) begin
        for (int i = 0; i < PAGES; i++) begin
          parts_q[i] <= 4'd0;
          obs_q[i]   <= 1'b0;
          rd_q[i]    <= '0;
        end
        hi_q  <= '0;
        any_q <= 1'b0;
      end else begin
        parts_q[cmd_page] <= n_parts;
        obs_q[cmd_page]   <= n_obs;
        rd_q[cmd_page]    <= n_rd;
        if (prog_ok) begin
          hi_q  <= cmd_page;
          any_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= 2'd0;
      rsp_parts    <= 4'd0;
      rsp_obsolete <= 1'b0;
      rsp_refresh  <= 1'b0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_code     <= code;
        rsp_parts    <= n_parts;
        rsp_obsolete <= n_obs;
        rsp_refresh  <= n_rd == CW'(READ_LIMIT);
      end
    end
  end

  assign rsp_used = |rsp_parts;
  assign rsp_full = &rsp_parts;

  always_comb begin
    all_obsolete = 1'b1;
    refresh_req  = 1'b0;
    for (int i = 0; i < PAGES; i++) begin
      if (parts_q[i] != 4'd0 && !obs_q[i]) all_obsolete = 1'b0;
      if (rd_q[i] == CW'(READ_LIMIT)) refresh_req = 1'b1;
    end
  end

endmodule

// File: rtl/nand_page_tracker_chk.sv
module nand_page_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic [3:0] rsp_parts,
  input logic       rsp_obsolete,
  input logic       rsp_refresh,
  input logic       all_obsolete,
  input logic       refresh_req
);
  AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid); // R1
  AST_PROG_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd0 |=> rsp_code != 2'd0 || rsp_parts == 4'hF); // R2
  AST_REWRITE_ON_USED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 2'd1 |-> rsp_parts != 4'd0); // R3
  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd4 |=> all_obsolete && !refresh_req && rsp_parts == 4'd0); // R6
  AST_INVAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd3 |=>
      (rsp_code == 2'd3 && rsp_parts == 4'd0) || (rsp_code == 2'd0 && rsp_obsolete)); // R7
  AST_REFRESH_USED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_refresh |-> rsp_parts != 4'd0 && refresh_req); // R8
endmodule

bind nand_page_tracker nand_page_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_parts(rsp_parts), .rsp_obsolete(rsp_obsolete), .rsp_refresh(rsp_refresh),
  .all_obsolete(all_obsolete), .refresh_req(refresh_req)
);

// File: tb/sim_nand_page_tracker.sv
`timescale 1ns/1ps
module sim_nand_page_tracker;
  localparam int PAGES = 32;
  localparam int LIM = 4;
  localparam int PW = $clog2(PAGES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [PW-1:0] cmd_page = '0;
  logic [1:0] cmd_part = 2'd0;
  logic rsp_valid, rsp_used, rsp_full, rsp_obsolete, rsp_refresh, all_obsolete, refresh_req;
  logic [1:0] rsp_code;
  logic [3:0] rsp_parts;

  int vectors = 0;
  int bad = 0;
  int mparts [PAGES];
  int mobs [PAGES];
  int mrd [PAGES];
  int mhi = 0;
  int many = 0;
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  nand_page_tracker #(.PAGES(PAGES), .READ_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_part(cmd_part),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_parts(rsp_parts),
    .rsp_used(rsp_used), .rsp_full(rsp_full), .rsp_obsolete(rsp_obsolete),
    .rsp_refresh(rsp_refresh), .all_obsolete(all_obsolete), .refresh_req(refresh_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_allobs();
    for (int i = 0; i < PAGES; i++) if (mparts[i] != 0 && mobs[i] == 0) return 0;
    return 1;
  endfunction

  function automatic int m_refr();
    for (int i = 0; i < PAGES; i++) if (mrd[i] == LIM) return 1;
    return 0;
  endfunction

  task automatic do_cmd(input int op, input int page, input int part);
    int ecode;
    int bitv;
    string req;
    bitv = 1 << part;
    ecode = 0;
    req = "R10";
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op[2:0];
    cmd_page = page[PW-1:0];
    cmd_part = part[1:0];
    if (op == 0 || op == 1) begin
      if (many != 0 && page < mhi) begin ecode = 2; req = "R4"; end
      else if (op == 0 && mparts[page] != 0) begin ecode = 1; req = "R3"; end
      else if (op == 1 && (mparts[page] & bitv) != 0) begin ecode = 1; req = "R3"; end
      else begin
        mparts[page] = (op == 0) ? 15 : (mparts[page] | bitv);
        mhi = page;
        many = 1;
        req = (op == 0) ? "R2" : "R5";
      end
    end else if (op == 2) begin
      req = "R8";
      if (mparts[page] == 0) ecode = 3;
      else if (mrd[page] < LIM) mrd[page]++;
    end else if (op == 3) begin
      req = "R7";
      if (mparts[page] == 0) ecode = 3;
      else mobs[page] = 1;
    end else if (op == 4) begin
      req = "R6";
      for (int i = 0; i < PAGES; i++) begin mparts[i] = 0; mobs[i] = 0; mrd[i] = 0; end
      mhi = 0;
      many = 0;
    end else ecode = 3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1", "rsp_valid", int'(rsp_valid), 1);
    chk(req, "code", int'(rsp_code), ecode);
    chk(req, "parts", int'(rsp_parts), mparts[page]);
    chk("R5", "used", int'(rsp_used), int'(mparts[page] != 0));
    chk("R5", "full", int'(rsp_full), int'(mparts[page] == 15));
    chk(req, "obsolete", int'(rsp_obsolete), mobs[page]);
    chk("R8", "rsp_refresh", int'(rsp_refresh), int'(mrd[page] == LIM));
    chk("R8", "refresh_req", int'(refresh_req), m_refr());
    chk("R9", "all_obsolete", int'(all_obsolete), m_allobs());
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES; i++) begin mparts[i] = 0; mobs[i] = 0; mrd[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(cmd_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready", int'(cmd_ready), 1);
    chk("R1", "idle rsp_valid", int'(rsp_valid), 0);
    chk("R9", "reset all_obsolete", int'(all_obsolete), 1);
    chk("R8", "reset refresh_req", int'(refresh_req), 0);
    // R5 quarters one at a time, R3 rewrites of each
    for (int q = 0; q < 4; q++) do_cmd(1, 0, q);
    for (int q = 0; q < 4; q++) do_cmd(1, 0, q);
    do_cmd(0, 0, 0);
    do_cmd(2, 5, 0);          // R8 read of free page
    do_cmd(3, 5, 0);          // R7 invalidate free page
    do_cmd(1, 3, 2);          // partial on page 3
    do_cmd(0, 2, 0);          // R4 below highest
    do_cmd(1, 3, 2);          // R4 not, R3 rewrite at highest
    do_cmd(1, 3, 1);
    do_cmd(0, 4, 0);          // R2
    do_cmd(1, 3, 1);          // R4 priority over R3
    for (int r = 0; r < LIM + 2; r++) do_cmd(2, 4, 0); // R8 limit and saturation
    do_cmd(3, 4, 0);
    do_cmd(3, 0, 0);
    do_cmd(3, 3, 0);          // R9 all used pages obsolete
    for (int op = 5; op < 8; op++) do_cmd(op, 1, 0); // R10
    do_cmd(4, 0, 0);          // R6
    do_cmd(0, 0, 0);          // R6 ordering reset
    do_cmd(0, PAGES - 1, 0);
    do_cmd(4, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      int r, op, pg;
      seed = seed * 32'd1103515245 + 32'd12345;
      r = int'(seed >> 8);
      case (r % 16)
        0, 1, 2: op = 0;
        3, 4, 5, 6: op = 1;
        7, 8, 9, 10: op = 2;
        11, 12: op = 3;
        13: op = ((r >> 4) % 4 == 0) ? 4 : 2;
        14: op = 5 + ((r >> 6) % 3);
        default: op = 2;
      endcase
      if ((r >> 10) % 2 == 0) pg = mhi + ((r >> 12) % 3) - 1;
      else pg = (r >> 14) % PAGES;
      if (pg < 0) pg = 0;
      if (pg >= PAGES) pg = PAGES - 1;
      do_cmd(op, pg, (r >> 20) % 4);
    end
    @(negedge clk);
    chk("R1", "final idle rsp_valid", int'(rsp_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule